// File: doc/BRIEF.md
# Display Register File with Strobed Parallel Host Bus

This block holds everything a host writes into a small eight-position dot-matrix display controller: one 8-bit code per digit position, a per-digit flash mask, a pointer that selects one of sixteen user-drawn glyphs, the 7-row by 5-column dot patterns of those glyphs, and an attribute register for brightness, flash, blink, self-test request and clear. The host reaches all of it through an asynchronous 8-bit bus with active-low chip enable, write and read strobes. A flash-select line and two mode lines choose the storage area, and a 3-bit address chooses the digit or the glyph row.

The host strobes are brought into the internal clock domain by two flip-flops, and a write takes effect once the rising edge of the write strobe is detected there. Reads are combinational from the current strobe and address inputs. The block runs the reset and clear sequences, each bounded to a few clocks, and flags them on a busy output. A scan side reads the digit codes and glyph rows through independent ports, for the font lookup and LED multiplexing logic that sits outside this block.

Top module: `dispreg_top`

## Requirements
- R1: With fsel_n low, the access reaches the flash mask whatever the mode lines are. addr selects the digit, data bit 0 is the flash bit, and the mask appears on flash_mask with bit i belonging to digit i.
- R2: With fsel_n high, mode selects the area. 2'b00 is the glyph pointer (data bits 3..0), 2'b01 is the glyph row RAM, 2'b11 is the digit code store (all 8 bits, digit 0 leftmost), and 2'b10 is the attribute register.
- R3: A write is committed once, on the detected rising edge of wr_n, only if cs_n was low while wr_n was low. A wr_n pulse with cs_n high changes nothing.
- R4: A digit code written with bit 7 = 0 is stored as the 7-bit font code in bits 6..0. With bit 7 = 1 it is stored as {1, 000, glyph index in bits 3..0}, so bits 6..4 read 0. scan_code returns the stored code of scan_digit.
- R5: A glyph row write stores data bits 4..0 into the glyph named by the pointer, at row addr (row 1 at addr 0 up to row 7 at addr 6). A 1 lights the dot, and scan_dots returns the row chosen by scan_glyph and scan_row.
- R6: While rst_n is low and for 3 clocks after it rises, busy is high. Reset leaves every digit code 8'h20, the flash mask 0 and the attribute register 0.
- R7: An attribute write with bit 7 = 1 sets every digit code to 8'h20 and the flash mask to 0, with busy high for 3 clocks. The other attribute bits keep the written values, and bit 7 reads back 0 afterwards.
- R8: A glyph row write with addr 7 is ignored, and row 7 reads back and scans as 0.
- R9: dout_oe is high and dout carries data only while cs_n and rd_n are both low; otherwise dout is 0. Read bits with no storage behind them return 0.
- R10: Attribute layout: bit 7 clear, bit 6 self-test request, bit 5 test result (read-only, reads 0, writes ignored), bit 4 blink, bit 3 flash, bits 2..0 brightness. These drive selftest_req, blink_en, flash_en and brightness.
- R11: A write whose commit falls while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low, commits on rise |
| rd_n | input | 1 | Read strobe, active low |
| fsel_n | input | 1 | Low selects the flash mask |
| mode | input | 2 | Area select when fsel_n is high |
| addr | input | 3 | Digit or glyph row address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| busy | output | 1 | Reset or clear in progress |
| scan_digit | input | 3 | Scan-side digit select |
| scan_code | output | 8 | Stored code of scan_digit |
| scan_glyph | input | 4 | Scan-side glyph select |
| scan_row | input | 3 | Scan-side glyph row select |
| scan_dots | output | 5 | Dot pattern of the selected glyph row |
| flash_mask | output | 8 | Per-digit flash bits |
| brightness | output | 3 | Brightness code |
| flash_en | output | 1 | Flash function enable |
| blink_en | output | 1 | Blink function enable |
| selftest_req | output | 1 | Self-test request bit |

## Verification
A wrong area decode or a wrong digit index shows up on the very next read, either as a changed neighbour or as an untouched target. It also shows at once on scan_code, scan_dots or flash_mask, which are driven straight from the stored state. A clear or reset that ends early or leaves a stale entry shows in the busy window, which is checked cycle by cycle after the commit edge, and in readback of the blanks just after it ends. A mistimed commit shows in the writes that land during busy, which must leave the old value on readback.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

    typedef enum logic [1:0] {
        AREA_GPTR = 2'b00,
        AREA_GROW = 2'b01,
        AREA_ATTR = 2'b10,
        AREA_CODE = 2'b11
    } area_e;

    typedef struct packed {
        logic       clr;
        logic       stest;
        logic       blink;
        logic       flash;
        logic [2:0] bright;
    } attr_t;

    localparam logic [7:0] BLANK_CODE = 8'h20;
    localparam int         BUS_W      = 8;
    localparam int         GIDX_W     = 4;

endpackage

// File: rtl/dispreg_strobe_sync.sv
module dispreg_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic cs_n,
    output logic commit
);
    typedef struct packed {
        logic [2:0] wr;
        logic [2:0] cs;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.wr = {s_q.wr[1:0], wr_n};
        s_d.cs = {s_q.cs[1:0], cs_n};
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // rising edge seen on stage 2, chip enable as it was while the strobe was low
    assign commit = s_q.wr[1] && !s_q.wr[2] && !s_q.cs[2];

    assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/dispreg_glyph_ram.sv
module dispreg_glyph_ram #(
    parameter int NUM  = 16,
    parameter int ROWS = 7,
    parameter int COLS = 5
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(NUM)-1:0]   wsel,
    input  logic [$clog2(ROWS+1)-1:0] wrow,
    input  logic [COLS-1:0]          wdata,
    input  logic [$clog2(NUM)-1:0]   rsel_a,
    input  logic [$clog2(ROWS+1)-1:0] rrow_a,
    output logic [COLS-1:0]          rdata_a,
    input  logic [$clog2(NUM)-1:0]   rsel_b,
    input  logic [$clog2(ROWS+1)-1:0] rrow_b,
    output logic [COLS-1:0]          rdata_b
);
    localparam int UW    = $clog2(NUM);
    localparam int RW    = $clog2(ROWS + 1);
    localparam int SLOTS = NUM * ROWS;
    localparam int IW    = $clog2(SLOTS);

    logic [COLS-1:0] mem_d [SLOTS];
    logic [COLS-1:0] mem_q [SLOTS];

    function automatic logic [IW-1:0] slot(input logic [UW-1:0] s, input logic [RW-1:0] r);
        return IW'(s) * IW'(ROWS) + IW'(r);
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (we && (wrow < RW'(ROWS))) begin
            mem_d[slot(wsel, wrow)] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata_a = (rrow_a < RW'(ROWS)) ? mem_q[slot(rsel_a, rrow_a)] : '0;
    assign rdata_b = (rrow_b < RW'(ROWS)) ? mem_q[slot(rsel_b, rrow_b)] : '0;

endmodule

// File: rtl/dispreg_top.sv
module dispreg_top #(
    parameter int DIGITS      = 8,
    parameter int GLYPHS      = 16,
    parameter int GROWS       = 7,
    parameter int GCOLS       = 5,
    parameter int SETTLE_CLKS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        wr_n,
    input  logic                        rd_n,
    input  logic                        fsel_n,
    input  logic [1:0]                  mode,
    input  logic [$clog2(DIGITS)-1:0]   addr,
    input  logic [7:0]                  din,
    output logic [7:0]                  dout,
    output logic                        dout_oe,
    output logic                        busy,
    input  logic [$clog2(DIGITS)-1:0]   scan_digit,
    output logic [7:0]                  scan_code,
    input  logic [$clog2(GLYPHS)-1:0]   scan_glyph,
    input  logic [$clog2(GROWS+1)-1:0]  scan_row,
    output logic [GCOLS-1:0]            scan_dots,
    output logic [DIGITS-1:0]           flash_mask,
    output logic [2:0]                  brightness,
    output logic                        flash_en,
    output logic                        blink_en,
    output logic                        selftest_req
);
    import dispreg_pkg::*;

    localparam int UAW = $clog2(GLYPHS);
    localparam int RW  = $clog2(GROWS + 1);
    localparam int CW  = $clog2(SETTLE_CLKS + 1);
    localparam logic [DIGITS-1:0][7:0] BLANKS = {DIGITS{BLANK_CODE}};

    typedef struct packed {
        logic [DIGITS-1:0][7:0] code;
        logic [DIGITS-1:0]      fmask;
        logic [UAW-1:0]         gptr;
        attr_t                  attr;
        logic [CW-1:0]          cnt;
    } state_t;

    localparam state_t RESET_ST = '{
        code:  BLANKS,
        fmask: '0,
        gptr:  '0,
        attr:  '0,
        cnt:   CW'(SETTLE_CLKS)
    };

    state_t st_d, st_q;
    logic   commit;
    logic   do_write;
    logic   row_we;
    logic [GCOLS-1:0] row_rd;
    logic [7:0]       rdata;
    area_e            area;

    dispreg_strobe_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .cs_n   (cs_n),
        .commit (commit)
    );

    assign area     = area_e'(mode);
    assign busy     = !rst_n || (st_q.cnt != '0);
    assign do_write = commit && !busy;
    assign row_we   = do_write && fsel_n && (area == AREA_GROW);

    dispreg_glyph_ram #(
        .NUM  (GLYPHS),
        .ROWS (GROWS),
        .COLS (GCOLS)
    ) u_glyphs (
        .clk     (clk),
        .we      (row_we),
        .wsel    (st_q.gptr),
        .wrow    (addr[RW-1:0]),
        .wdata   (din[GCOLS-1:0]),
        .rsel_a  (scan_glyph),
        .rrow_a  (scan_row),
        .rdata_a (scan_dots),
        .rsel_b  (st_q.gptr),
        .rrow_b  (addr[RW-1:0]),
        .rdata_b (row_rd)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (st_q.attr.clr) begin
            st_d.code  = BLANKS;
            st_d.fmask = '0;
            if (st_q.cnt == CW'(1)) begin
                st_d.attr.clr = 1'b0;
            end
        end
        if (do_write) begin
            if (!fsel_n) begin
                st_d.fmask[addr] = din[0];
            end else begin
                unique case (area)
                    AREA_GPTR: st_d.gptr = din[UAW-1:0];
                    AREA_GROW: ;
                    AREA_CODE: st_d.code[addr] = din[7] ? {1'b1, 3'b000, din[GIDX_W-1:0]}
                                                        : {1'b0, din[6:0]};
                    AREA_ATTR: begin
                        st_d.attr = '{clr: din[7], stest: din[6], blink: din[4],
                                      flash: din[3], bright: din[2:0]};
                        if (din[7]) begin
                            st_d.cnt = CW'(SETTLE_CLKS);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (!fsel_n) begin
            rdata[0] = st_q.fmask[addr];
        end else begin
            unique case (area)
                AREA_GPTR: rdata[UAW-1:0]   = st_q.gptr;
                AREA_GROW: rdata[GCOLS-1:0] = row_rd;
                AREA_CODE: rdata            = st_q.code[addr];
                AREA_ATTR: rdata = {st_q.attr.clr, st_q.attr.stest, 1'b0, st_q.attr.blink,
                                    st_q.attr.flash, st_q.attr.bright};
                default:   rdata = '0;
            endcase
        end
    end

    assign dout_oe      = !cs_n && !rd_n;
    assign dout         = dout_oe ? rdata : '0;
    assign scan_code    = st_q.code[scan_digit];
    assign flash_mask   = st_q.fmask;
    assign brightness   = st_q.attr.bright;
    assign flash_en     = st_q.attr.flash;
    assign blink_en     = st_q.attr.blink;
    assign selftest_req = st_q.attr.stest;

    // checker: length of the current busy run after reset release
    logic [CW:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy) begin
            busy_run_q <= busy_run_q + 1'b1;
        end else begin
            busy_run_q <= '0;
        end
    end

    assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= (CW + 1)'(SETTLE_CLKS));

    assert_clear_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.attr.clr) |-> (st_q.code == BLANKS && st_q.fmask == '0));

    assert_bus_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (dout == '0 && !dout_oe));

    assert_frozen_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.gptr));

endmodule

// File: tb/dispreg_top_tb.sv
module dispreg_top_tb;

    typedef struct packed {
        logic [3:0] req;
        logic       fsel;
        logic [1:0] mode;
        logic [2:0] adr;
        logic [7:0] wdat;
        logic [7:0] exp;
    } vec_t;

    // R1 flash mask, R2 area decode, R4 code types, R5 glyph rows, R8 row 7, R10 attribute layout
    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{4'd4,  1'b1, 2'b11, 3'd0, 8'h53, 8'h53},
        '{4'd2,  1'b1, 2'b11, 3'd7, 8'h45, 8'h45},
        '{4'd4,  1'b1, 2'b11, 3'd2, 8'hFA, 8'h8A},
        '{4'd1,  1'b0, 2'b10, 3'd3, 8'hFF, 8'h01},
        '{4'd1,  1'b0, 2'b11, 3'd5, 8'h01, 8'h01},
        '{4'd2,  1'b1, 2'b00, 3'd0, 8'hA5, 8'h05},
        '{4'd5,  1'b1, 2'b01, 3'd0, 8'hEE, 8'h0E},
        '{4'd5,  1'b1, 2'b01, 3'd6, 8'h11, 8'h11},
        '{4'd8,  1'b1, 2'b01, 3'd7, 8'h1F, 8'h00},
        '{4'd10, 1'b1, 2'b10, 3'd0, 8'h7B, 8'h5B},
        '{4'd10, 1'b1, 2'b10, 3'd0, 8'h02, 8'h02}
    };

    logic       clk = 1'b0;
    logic       rst_n, cs_n, wr_n, rd_n, fsel_n;
    logic [1:0] mode;
    logic [2:0] addr;
    logic [7:0] din;
    logic [7:0] dout;
    logic       dout_oe, busy;
    logic [2:0] scan_digit;
    logic [7:0] scan_code;
    logic [3:0] scan_glyph;
    logic [2:0] scan_row;
    logic [4:0] scan_dots;
    logic [7:0] flash_mask;
    logic [2:0] brightness;
    logic       flash_en, blink_en, selftest_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dispreg_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .fsel_n(fsel_n), .mode(mode), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .busy(busy),
        .scan_digit(scan_digit), .scan_code(scan_code),
        .scan_glyph(scan_glyph), .scan_row(scan_row), .scan_dots(scan_dots),
        .flash_mask(flash_mask), .brightness(brightness), .flash_en(flash_en),
        .blink_en(blink_en), .selftest_req(selftest_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic f, input logic [1:0] m, input logic [2:0] a,
                             input logic [7:0] d, input logic sel);
        if (busy) begin
            fails++;
            $display("FAIL R11 access while busy actual=1 expected=0");
        end
        @(negedge clk);
        fsel_n = f; mode = m; addr = a; din = d;
        cs_n = !sel; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic f, input logic [1:0] m, input logic [2:0] a,
                            output logic [7:0] v);
        if (busy) begin
            fails++;
            $display("FAIL R11 access while busy actual=1 expected=0");
        end
        @(negedge clk);
        fsel_n = f; mode = m; addr = a;
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        v = dout;
        check("R9 oe during read", dout_oe, 1);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; fsel_n = 1'b1;
        mode = 2'b00; addr = '0; din = '0;
        scan_digit = '0; scan_glyph = '0; scan_row = '0;

        // R6: busy during and for 3 clocks after reset
        repeat (5) @(negedge clk);
        #1 check("R6 busy in reset", busy, 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R6 busy at release", busy, 1);
        repeat (2) @(negedge clk);
        #1 check("R6 busy 2 clocks after", busy, 1);
        @(negedge clk);
        #1 check("R6 busy 3 clocks after", busy, 0);
        bus_read(1'b1, 2'b11, 3'd0, v); check("R6 digit0 blank", v, 8'h20);
        bus_read(1'b1, 2'b11, 3'd5, v); check("R6 digit5 blank", v, 8'h20);
        bus_read(1'b1, 2'b10, 3'd0, v); check("R6 attr zero", v, 8'h00);
        check("R6 mask zero", flash_mask, 8'h00);

        // table of write / readback vectors
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i].fsel, VEC[i].mode, VEC[i].adr, VEC[i].wdat, 1'b1);
            bus_read(VEC[i].fsel, VEC[i].mode, VEC[i].adr, v);
            checks++;
            if (v !== VEC[i].exp) begin
                fails++;
                $display("FAIL R%0d vector %0d actual=%0h expected=%0h", VEC[i].req, i, v, VEC[i].exp);
            end
        end
        // R10: 0x7B was followed by 0x02
        check("R10 brightness", brightness, 3'd2);
        check("R10 blink off", blink_en, 0);
        check("R10 selftest off", selftest_req, 0);
        // R1: digits 3 and 5 flagged
        check("R1 mask port", flash_mask, 8'h28);

        // R4 / R5 / R8: scan ports
        @(negedge clk);
        scan_digit = 3'd0; #1 check("R4 scan digit0", scan_code, 8'h53);
        scan_digit = 3'd2; #1 check("R4 scan glyph code", scan_code, 8'h8A);
        scan_glyph = 4'd5; scan_row = 3'd0; #1 check("R5 scan row1", scan_dots, 5'h0E);
        scan_row = 3'd6; #1 check("R5 scan row7 of glyph", scan_dots, 5'h11);
        scan_row = 3'd7; #1 check("R8 scan addr7", scan_dots, 5'h00);
        bus_read(1'b1, 2'b01, 3'd6, v); check("R8 row6 kept", v, 8'h11);

        // R9: bus idle with read strobe high
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1; fsel_n = 1'b1; mode = 2'b11; addr = 3'd0;
        #1 check("R9 oe idle", dout_oe, 0);
        check("R9 dout idle", dout, 8'h00);
        cs_n = 1'b1;

        // R3: write pulse without chip enable
        bus_write(1'b1, 2'b11, 3'd7, 8'h77, 1'b0);
        bus_read(1'b1, 2'b11, 3'd7, v); check("R3 cs high ignored", v, 8'h45);

        // R7: clear via attribute bit 7
        bus_write(1'b1, 2'b10, 3'd0, 8'h89, 1'b1);
        #1 check("R7 busy during clear", busy, 1);
        @(negedge clk);
        #1 check("R7 clear done in 3", busy, 0);
        bus_read(1'b1, 2'b11, 3'd0, v); check("R7 digit0 blank", v, 8'h20);
        bus_read(1'b1, 2'b11, 3'd7, v); check("R7 digit7 blank", v, 8'h20);
        check("R7 mask cleared", flash_mask, 8'h00);
        bus_read(1'b1, 2'b10, 3'd0, v); check("R7 clear bit self-resets", v, 8'h09);
        check("R7 flash kept", flash_en, 1);
        check("R7 brightness kept", brightness, 3'd1);
        bus_read(1'b1, 2'b00, 3'd0, v); check("R7 pointer untouched", v, 8'h05);

        // R11: write committing inside the post-reset busy window
        @(negedge clk);
        rst_n = 1'b0;
        fsel_n = 1'b1; mode = 2'b11; addr = 3'd0; din = 8'h41;
        cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        #1 check("R11 busy over", busy, 0);
        bus_read(1'b1, 2'b11, 3'd0, v); check("R11 write in busy ignored", v, 8'h20);

        summary();
    end

endmodule